// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block takes interrupt messages arriving from an external bus and keeps one single-entry mailbox for each CPU. A message names a target CPU, carries a 5-bit source identifier and two 64-bit data words. If the target mailbox is empty, the block stores the message in the same cycle and reports acceptance on `msg_accept`. It marks the mailbox busy and, one cycle later, posts one programmable vector to that CPU. If the mailbox is already busy, the message is refused and dropped, and the sender is expected to retry.

CPUs reach the mailboxes through a register port with byte addresses and 8-byte words. Each mailbox can be read by explicit index: data word 0, data word 1, and a status word with busy and source. There are also alias addresses that select the mailbox of the CPU issuing the access, given on `reg_req_cpu`. A CPU frees its mailbox by writing the status word with the busy bit cleared.

Each mailbox is a two-state machine, with states `SLOT_FREE` and `SLOT_HELD`. Its transitions are:
- CAPTURE (`SLOT_FREE` to `SLOT_HELD`): a message is accepted.
- SET_BY_CPU (`SLOT_FREE` to `SLOT_HELD`): a status write with busy = 1.
- RELEASE (`SLOT_HELD` to `SLOT_FREE`): a status write with busy = 0 and no message in that cycle.
- RECAPTURE (`SLOT_HELD` to `SLOT_HELD`): a release write and a message for that slot arrive in the same cycle.

Address map: the region is byte address bits [9:8], the index is bits [7:3], and bits [2:0] are ignored. Region 0 holds data word 0, region 1 holds data word 1, region 2 holds status, and region 3 holds the special registers. In region 3, index 0 is the vector, 1 is alias data 0, 2 is alias data 1 and 3 is alias status.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After reset every mailbox is free, with source and data zero, and the vector register is zero. `msg_accept`, `post_valid` and `rd_valid` are 0.
- R2: A message to a free mailbox raises `msg_accept` in the same cycle. From the next cycle the mailbox is busy and holds the message's source and both data words.
- R3: A message to a busy mailbox gives `msg_accept` = 0. The mailbox's source and data stay unchanged and nothing is posted.
- R4: The cycle after an accepted message, `post_valid` is 1 for exactly one cycle. In that cycle `post_cpu` is the target CPU and `post_vec` is the vector register value from the acceptance cycle.
- R5: A write to region 3 index 0 loads the vector from data bits [5:0]. A read returns it zero-extended.
- R6: The status word has busy in bit 5 and the source in bits [4:0]. All other bits are 0.
- R7: A read in region 0, 1 or 2 returns data word 0, data word 1 or status of the mailbox selected by address bits [7:3].
- R8: Alias reads (region 3 index 1, 2, 3) return data word 0, data word 1 or status of the mailbox numbered `reg_req_cpu`. An alias status write acts on that mailbox.
- R9: A status write loads busy from data bit 5. Writing 0 frees the mailbox and keeps its source. Writing 1 makes it busy without changing source or data.
- R10: When a status write and a message hit the same mailbox in one cycle, the write is applied first, and acceptance is judged on the busy value it leaves.
- R11: `rd_valid` is 1 in the cycle after a read request. `rd_data` then shows the state from before that clock edge.
- R12: Writes to regions 0 and 1, and to unused region-3 indices, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming message present |
| msg_cpu | input | 5 | Target CPU of the message |
| msg_src | input | 5 | Source identifier |
| msg_d0 | input | 64 | Message data word 0 |
| msg_d1 | input | 64 | Message data word 1 |
| msg_accept | output | 1 | Message stored (same cycle); 0 means retry |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | CPU receiving the post |
| post_vec | output | 6 | Vector posted |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte address |
| reg_req_cpu | input | 5 | CPU issuing the access (for aliases) |
| reg_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |

## Verification
`msg_accept` is combinational and is due in the cycle the message is driven. The bench therefore samples it shortly after driving its inputs at the falling edge, before the next rising edge. Slot state, `post_valid`/`post_cpu`/`post_vec`, and `rd_valid`/`rd_data` are each one register deep. They are sampled one time unit after the rising edge that captures the stimulus. Effects of writes are checked with a read in a later cycle, and the read issued in the same cycle as a capture confirms that reads see the pre-edge state.

// File: rtl/cim_pkg.sv
package cim_pkg;
    localparam int SRC_W    = 5;
    localparam int VEC_W    = 6;
    localparam int BUSY_BIT = 5;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        RGN_DATA0 = 2'd0,
        RGN_DATA1 = 2'd1,
        RGN_STAT  = 2'd2,
        RGN_MISC  = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_D0   = 3'd1,
        TGT_D1   = 3'd2,
        TGT_STAT = 3'd3,
        TGT_VEC  = 3'd4
    } target_e;
endpackage

// File: rtl/cim_decode.sv
module cim_decode
    import cim_pkg::*;
#(
    parameter int CPU_W  = 5,
    parameter int ADDR_W = CPU_W + 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CPU_W-1:0]  req_cpu,
    output target_e           tgt,
    output logic [CPU_W-1:0]  slot
);
    region_e           rgn;
    logic [CPU_W-1:0]  idx;
    logic              unused_low;

    assign rgn        = region_e'(addr[ADDR_W-1 -: 2]);
    assign idx        = addr[3 +: CPU_W];
    assign unused_low = ^addr[2:0];

    always_comb begin
        tgt  = TGT_NONE;
        slot = idx;
        unique case (rgn)
            RGN_DATA0: tgt = TGT_D0;
            RGN_DATA1: tgt = TGT_D1;
            RGN_STAT:  tgt = TGT_STAT;
            RGN_MISC: begin
                slot = req_cpu;
                if (idx == CPU_W'(0))      tgt = TGT_VEC;
                else if (idx == CPU_W'(1)) tgt = TGT_D0;
                else if (idx == CPU_W'(2)) tgt = TGT_D1;
                else if (idx == CPU_W'(3)) tgt = TGT_STAT;
                else                       tgt = TGT_NONE;
            end
        endcase
    end
endmodule

// File: rtl/cim_slot.sv
module cim_slot
    import cim_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_hit,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic [DATA_W-1:0] msg_d0,
    input  logic [DATA_W-1:0] msg_d1,
    input  logic              wr_hit,
    input  logic              wr_busy,
    output logic              take,
    output logic              busy,
    output logic [SRC_W-1:0]  src_q,
    output logic [DATA_W-1:0] d0_q,
    output logic [DATA_W-1:0] d1_q
);
    slot_state_e state, state_nxt;
    logic        busy_eff;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_FREE;
        else        state <= state_nxt;
    end

    // next state: a CPU write lands before the message is judged
    always_comb begin
        busy_eff = (state == SLOT_HELD);
        if (wr_hit) busy_eff = wr_busy;
        take      = msg_hit && !busy_eff;
        state_nxt = state;
        unique case (state)
            SLOT_FREE: begin
                if (take)                   state_nxt = SLOT_HELD; // CAPTURE
                else if (wr_hit && wr_busy) state_nxt = SLOT_HELD; // SET_BY_CPU
            end
            SLOT_HELD: begin
                if (take)                    state_nxt = SLOT_HELD; // RECAPTURE
                else if (wr_hit && !wr_busy) state_nxt = SLOT_FREE; // RELEASE
            end
        endcase
    end

    // outputs
    always_comb begin
        busy = (state == SLOT_HELD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
        end else if (take) begin
            src_q <= msg_src;
            d0_q  <= msg_d0;
            d1_q  <= msg_d1;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && src_q == $past(msg_src) && d0_q == $past(msg_d0)))
        else $error("slot did not capture accepted message");

    assert_refuse_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_hit && msg_hit) |=> ($stable(src_q) && $stable(d1_q) && busy))
        else $error("busy slot changed on refused message");

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wr_busy && !msg_hit) |=> (!busy && $stable(src_q)))
        else $error("release write did not free slot");

    assert_write_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_busy && msg_hit) |-> !take)
        else $error("message accepted over same-cycle busy write");
endmodule

// File: rtl/cpu_irq_mailbox.sv
module cpu_irq_mailbox
    import cim_pkg::*;
#(
    parameter int NCPU   = 32,
    parameter int DATA_W = 64,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int ADDR_W = CPU_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [CPU_W-1:0]  msg_cpu,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic [DATA_W-1:0] msg_d0,
    input  logic [DATA_W-1:0] msg_d1,
    output logic              msg_accept,
    output logic              post_valid,
    output logic [CPU_W-1:0]  post_cpu,
    output logic [VEC_W-1:0]  post_vec,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CPU_W-1:0]  reg_req_cpu,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    target_e           dec_tgt;
    logic [CPU_W-1:0]  dec_slot;
    logic [VEC_W-1:0]  vec_q;
    logic [NCPU-1:0]   take_v;
    logic [NCPU-1:0]   busy_v;
    logic [SRC_W-1:0]  src_a [NCPU];
    logic [DATA_W-1:0] d0_a  [NCPU];
    logic [DATA_W-1:0] d1_a  [NCPU];
    logic [DATA_W-1:0] rd_nxt;
    logic              wr_stat;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:VEC_W];

    cim_decode #(.CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_dec (
        .addr    (reg_addr),
        .req_cpu (reg_req_cpu),
        .tgt     (dec_tgt),
        .slot    (dec_slot)
    );

    assign wr_stat = reg_en && reg_we && (dec_tgt == TGT_STAT);

    for (genvar g = 0; g < NCPU; g++) begin : g_slot
        cim_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .msg_hit (msg_valid && (msg_cpu == CPU_W'(g))),
            .msg_src (msg_src),
            .msg_d0  (msg_d0),
            .msg_d1  (msg_d1),
            .wr_hit  (wr_stat && (dec_slot == CPU_W'(g))),
            .wr_busy (reg_wdata[BUSY_BIT]),
            .take    (take_v[g]),
            .busy    (busy_v[g]),
            .src_q   (src_a[g]),
            .d0_q    (d0_a[g]),
            .d1_q    (d1_a[g])
        );
    end

    assign msg_accept = |take_v;

    // shared vector register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       vec_q <= '0;
        else if (reg_en && reg_we && dec_tgt == TGT_VEC)  vec_q <= reg_wdata[VEC_W-1:0];
    end

    // post strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
        end else begin
            post_valid <= msg_accept;
            post_cpu   <= msg_cpu;
            post_vec   <= vec_q;
        end
    end

    // read select
    always_comb begin
        rd_nxt = '0;
        unique case (dec_tgt)
            TGT_D0:   rd_nxt = d0_a[dec_slot];
            TGT_D1:   rd_nxt = d1_a[dec_slot];
            TGT_STAT: begin
                rd_nxt[SRC_W-1:0] = src_a[dec_slot];
                rd_nxt[BUSY_BIT]  = busy_v[dec_slot];
            end
            TGT_VEC:  rd_nxt[VEC_W-1:0] = vec_q;
            TGT_NONE: rd_nxt = '0;
            default:  rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= reg_en && !reg_we;
            if (reg_en && !reg_we) rd_data <= rd_nxt;
        end
    end

    assert_one_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_v))
        else $error("more than one slot accepted");

    assert_post_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_accept |=> (post_valid && post_cpu == $past(msg_cpu) && post_vec == $past(vec_q)))
        else $error("post missing after acceptance");

    assert_no_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_accept |=> !post_valid)
        else $error("post without acceptance");

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we) |=> rd_valid)
        else $error("read data not valid one cycle later");

    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> (!rd_valid && $stable(rd_data)))
        else $error("read valid without request");
endmodule

// File: tb/sim_cpu_irq_mailbox.sv
module sim_cpu_irq_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [4:0]  msg_cpu = '0;
    logic [4:0]  msg_src = '0;
    logic [63:0] msg_d0 = '0;
    logic [63:0] msg_d1 = '0;
    logic        msg_accept;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [4:0]  reg_req_cpu = '0;
    logic [63:0] reg_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic        acc_s, post_s, rdv_s;
    logic [4:0]  pcpu_s;
    logic [5:0]  pvec_s;
    logic [63:0] rdd_s;

    localparam logic [63:0] BASE = 64'hA5C3_0000_0000_0000;
    localparam int NT = 6;
    // {cpu, src, expected accept}
    localparam logic [10:0] TBL [NT] = '{
        {5'd3,  5'd7,  1'b1},
        {5'd3,  5'd9,  1'b0},
        {5'd31, 5'd1,  1'b1},
        {5'd0,  5'd31, 1'b1},
        {5'd31, 5'd2,  1'b0},
        {5'd0,  5'd4,  1'b0}
    };

    always #4 clk = ~clk;

    cpu_irq_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
        .msg_d0(msg_d0), .msg_d1(msg_d1), .msg_accept(msg_accept),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_req_cpu(reg_req_cpu), .reg_wdata(reg_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [9:0] adr(input int rgn, input int idx);
        return {rgn[1:0], idx[4:0], 3'b000};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit mv, input int mc, input int ms,
                        input logic [63:0] m0, input logic [63:0] m1,
                        input bit re, input bit we, input logic [9:0] ad,
                        input int rc, input logic [63:0] wd);
        @(negedge clk);
        msg_valid = mv; msg_cpu = mc[4:0]; msg_src = ms[4:0];
        msg_d0 = m0; msg_d1 = m1;
        reg_en = re; reg_we = we; reg_addr = ad; reg_req_cpu = rc[4:0]; reg_wdata = wd;
        #1 acc_s = msg_accept;
        @(posedge clk);
        #1;
        post_s = post_valid; pcpu_s = post_cpu; pvec_s = post_vec;
        rdv_s = rd_valid; rdd_s = rd_data;
        msg_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic send(input int c, input int s, input logic [63:0] d0, input logic [63:0] d1);
        step(1'b1, c, s, d0, d1, 1'b0, 1'b0, '0, 0, '0);
    endtask

    task automatic wr(input logic [9:0] ad, input int rc, input logic [63:0] wd);
        step(1'b0, 0, 0, '0, '0, 1'b1, 1'b1, ad, rc, wd);
    endtask

    task automatic rd(input logic [9:0] ad, input int rc, output logic [63:0] v);
        step(1'b0, 0, 0, '0, '0, 1'b1, 1'b0, ad, rc, '0);
        v = rdd_s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 post_valid", {63'b0, post_valid}, 64'd0);
        chk("R1 rd_valid", {63'b0, rd_valid}, 64'd0);
        chk("R1 accept idle", {63'b0, msg_accept}, 64'd0);
        @(negedge clk) rst_n = 1'b1;

        rd(adr(2, 5), 0, v);  chk("R1 status zero", v, 64'd0);
        rd(adr(0, 7), 0, v);  chk("R1 data0 zero", v, 64'd0);
        rd(adr(3, 0), 0, v);  chk("R1 vector zero", v, 64'd0);
        chk("R11 rd_valid", {63'b0, rdv_s}, 64'd1);
        step(1'b0, 0, 0, '0, '0, 1'b0, 1'b0, '0, 0, '0);
        chk("R11 rd_valid drops", {63'b0, rdv_s}, 64'd0);

        wr(adr(3, 0), 0, 64'hFFFF_FFFF_FFFF_FFEA);
        rd(adr(3, 0), 0, v);  chk("R5 vector readback", v, 64'h2A);

        // message table
        for (int k = 0; k < NT; k++) begin
            int c, s;
            bit e;
            c = int'(TBL[k][10:6]); s = int'(TBL[k][5:1]); e = TBL[k][0];
            send(c, s, BASE | 64'(k), ~(BASE | 64'(k)));
            chk(e ? "R2 accept" : "R3 refuse", {63'b0, acc_s}, {63'b0, e});
            chk("R4 post_valid", {63'b0, post_s}, {63'b0, e});
            if (e) begin
                chk("R4 post_cpu", {59'b0, pcpu_s}, 64'(c));
                chk("R4 post_vec", {58'b0, pvec_s}, 64'h2A);
            end
        end
        step(1'b0, 0, 0, '0, '0, 1'b0, 1'b0, '0, 0, '0);
        chk("R4 single pulse", {63'b0, post_s}, 64'd0);

        rd(adr(2, 3), 0, v);  chk("R6 status cpu3", v, 64'h27);
        rd(adr(0, 3), 0, v);  chk("R7/R3 data0 cpu3", v, BASE);
        rd(adr(1, 3), 0, v);  chk("R7/R3 data1 cpu3", v, ~BASE);
        rd(adr(2, 31), 0, v); chk("R6 status cpu31", v, 64'h21);

        rd(adr(3, 1), 31, v); chk("R8 alias data0", v, BASE | 64'd2);
        rd(adr(3, 3), 31, v); chk("R8 alias status", v, 64'h21);
        rd(adr(3, 2), 0, v);  chk("R8 alias data1", v, ~(BASE | 64'd3));

        wr(adr(0, 3), 0, 64'h1234);
        wr(adr(1, 3), 0, 64'h5678);
        wr(adr(3, 9), 0, 64'h3F);
        rd(adr(0, 3), 0, v);  chk("R12 data0 write ignored", v, BASE);
        rd(adr(1, 3), 0, v);  chk("R12 data1 write ignored", v, ~BASE);
        rd(adr(3, 0), 0, v);  chk("R12 vector untouched", v, 64'h2A);

        wr(adr(2, 3), 0, 64'h0);
        rd(adr(2, 3), 0, v);  chk("R9 release keeps source", v, 64'h07);
        send(3, 12, 64'd1, 64'd2);
        chk("R2 accept after release", {63'b0, acc_s}, 64'd1);

        wr(adr(2, 5), 0, 64'h20);
        rd(adr(2, 5), 0, v);  chk("R9 set busy", v, 64'h20);
        send(5, 3, '0, '0);
        chk("R9/R3 refused after set", {63'b0, acc_s}, 64'd0);

        // same-cycle release and message
        step(1'b1, 5, 17, 64'd9, 64'd9, 1'b1, 1'b1, adr(2, 5), 0, 64'h0);
        chk("R10 release then accept", {63'b0, acc_s}, 64'd1);
        rd(adr(2, 5), 0, v);  chk("R10 status after", v, 64'h31);
        // same-cycle set and message via alias
        step(1'b1, 6, 2, '0, '0, 1'b1, 1'b1, adr(3, 3), 6, 64'h20);
        chk("R10 set then refuse", {63'b0, acc_s}, 64'd0);
        rd(adr(2, 6), 0, v);  chk("R8/R10 alias set busy", v, 64'h20);

        // read in same cycle as capture sees old state
        step(1'b1, 7, 11, '0, '0, 1'b1, 1'b0, adr(2, 7), 0, '0);
        chk("R11 pre-edge read", rdd_s, 64'h0);
        rd(adr(2, 7), 0, v);  chk("R11 later read", v, 64'h2B);

        wr(adr(3, 0), 0, 64'h15);
        send(8, 1, '0, '0);
        chk("R5 new vector posted", {58'b0, pvec_s}, 64'h15);
        chk("R4 post_cpu 8", {59'b0, pcpu_s}, 64'd8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule